// File: doc/BRIEF.md
# Free-Running Match Interrupt Timer

This block is an up-counter driven by a fixed reference clock. Software steers it through a small synchronous register port with three registers: a control word, a compare value and a read-only count. The control word has two independent bits. One lets the counter advance and the other forces it to zero. While counting, the counter wraps from all ones to zero without stopping.

Each time the counter steps onto a value equal to a non-zero compare value, the block raises a one-cycle interrupt pulse. A compare value of zero turns the interrupt off. A counter that is parked on the compare value does not produce a pulse. A compare value written to equal the current count does not produce one either. The counter width is a parameter and defaults to 32 bits.

Top module: `match_timer`

## Requirements
- R1: After reset the count, the compare value, the run bit and the clear bit are all zero, and the interrupt output is low.
- R2: The register port decodes address 0 as control (bit 0 = run, bit 1 = clear), address 1 as the compare value and address 2 as the read-only count. A write lands on the clock edge where write enable is high. Read data follows the address combinationally. Address 3 reads zero.
- R3: While run is 1 and clear is 0, the count rises by exactly one on every clock edge.
- R4: While run is 0 and clear is 0, the count holds its value. Setting run again resumes counting from that held value.
- R5: While clear is 1, the count is forced to zero and held there whatever run is. After clear returns to 0 with run set, the count reads 1 one clock later.
- R6: The interrupt is high for exactly one cycle, in the cycle where the count has just advanced onto a value equal to a non-zero compare value.
- R7: While the compare value is zero, the interrupt never fires, even as the count passes through zero.
- R8: The count wraps from all ones to zero and keeps running, and the interrupt fires again on every lap.
- R9: No interrupt fires while the count is frozen at the compare value, nor when the compare value is rewritten to equal the present count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that drives the counter |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| addr | input | 2 | Register address for writes and reads |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data for the register at addr |
| irqPulse | output | 1 | One-cycle match interrupt |

## Verification
On every cycle the assertions check how the count moves: a step of one under run, a hold without run, zero under clear. They also check that the pulse never lasts two cycles, never appears with a zero compare value and only follows a real advance. Whether a pulse appears at the right cycle can only be shown by the bench's scenarios. These cover an ordinary match, the repeat after a wrap, the silence with a zero compare value, and the absence of a pulse when the count is parked on the compare value. The bench runs the counter at a narrow width so that a full lap fits in the run.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MATCH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
  localparam int RUN_BIT = 0;
  localparam int CLR_BIT = 1;

  // Strobes from the control side to the counter datapath
  typedef struct packed {
    logic advance;
    logic zero;
  } cntStrobe_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  rdData,
  output logic [CNT_W-1:0]  matchVal,
  output cntStrobe_t        strobe
);
  logic runBit;
  logic clrBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      clrBit   <= 1'b0;
      matchVal <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) begin
        runBit <= wrData[RUN_BIT];
        clrBit <= wrData[CLR_BIT];
      end
      if (addr == ADDR_MATCH) matchVal <= wrData;
    end
  end

  always_comb begin
    strobe.zero    = clrBit;
    strobe.advance = runBit && !clrBit;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdData[RUN_BIT] = runBit;
        rdData[CLR_BIT] = clrBit;
      end
      ADDR_MATCH: rdData = matchVal;
      ADDR_COUNT: rdData = countVal;
      default:    rdData = '0;
    endcase
  end

  // R2: a compare write is visible on the next clock
  a_r2_match_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_MATCH) |=> (matchVal == $past(wrData)));

  // R5: clear dominates run
  a_r5_clear_dominates: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |-> !strobe.advance);
endmodule

// File: rtl/mtimer_datapath.sv
module mtimer_datapath
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] countVal,
  output logic             irqPulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic stepped;  // count changed by an increment on the last edge

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      stepped  <= 1'b0;
    end else begin
      stepped <= strobe.advance;
      if (strobe.zero)         countVal <= '0;
      else if (strobe.advance) countVal <= countVal + ONE;
    end
  end

  always_comb irqPulse = stepped && (countVal == matchVal) && (matchVal != '0);

  // R3: one step per advancing edge, wrapping naturally
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (countVal == $past(countVal) + ONE));

  // R4: idle holds the count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.zero) |=> $stable(countVal));

  // R5: clear forces zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> (countVal == '0));

  // R6: pulse is one cycle wide
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R7: zero compare value silences the interrupt
  a_r7_zero_match: assert property (@(posedge clk) disable iff (!rstN)
    (matchVal == '0) |-> !irqPulse);

  // R9: a pulse only follows a real advance
  a_r9_needs_step: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strobe.advance));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqPulse
);
  cntStrobe_t       strobe;
  logic [CNT_W-1:0] matchVal;
  logic [CNT_W-1:0] countVal;

  mtimer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .countVal(countVal), .rdData(rdData), .matchVal(matchVal), .strobe(strobe)
  );

  mtimer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchVal(matchVal),
    .countVal(countVal), .irqPulse(irqPulse)
  );

  // R1: quiet output during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !irqPulse);
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int W = 8;
  localparam int LAP = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         irqPulse;

  match_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int expQ[$];
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic expHit;
  bit done = 1'b0;

  // Monitor: pops expected pulse cycles and compares with irqPulse
  always @(negedge clk) begin
    if (rstN && !done) begin
      expHit = (expQ.size() > 0) && (expQ[0] == cyc);
      if (irqPulse) pulses++;
      if (expHit) begin
        checks++;
        void'(expQ.pop_front());
        if (!irqPulse) begin
          errors++;
          $display("FAIL R6/R8: irqPulse act=0 exp=1 at cycle %0d", cyc);
        end
      end else if (irqPulse) begin
        checks++;
        errors++;
        $display("FAIL R6/R7/R9: irqPulse act=1 exp=0 at cycle %0d", cyc);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, output int c);
    @(negedge clk);
    c = cyc;
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v, output int c);
    @(negedge clk);
    addr = a;
    #1;
    v = int'(rdData);
    c = cyc;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    finishRun();
  end

  initial begin
    int c, cR, v, t, f, p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(2'd0, v, t); chk("R1 ctrl", v, 0);
    rd(2'd1, v, t); chk("R1 match", v, 0);
    rd(2'd2, v, t); chk("R1 count", v, 0);
    chk("R1 irq", int'(irqPulse), 0);

    // R2: compare register write and read back; address 3 reads zero
    wr(2'd1, 8'd5, c);
    rd(2'd1, v, t); chk("R2 match readback", v, 5);
    rd(2'd3, v, t); chk("R2 unused address", v, 0);

    // R3/R6/R8: run, pulse at 5 and again after one lap
    wr(2'd0, 8'd1, c);
    expQ.push_back(c + 1 + 5);
    expQ.push_back(c + 1 + 5 + LAP);
    repeat (10) @(negedge clk);
    rd(2'd2, v, t); chk("R3 count", v, (t - c - 1) % LAP);
    rd(2'd0, v, t); chk("R2 ctrl readback", v, 1);
    wait (cyc > c + 1 + 5 + LAP + 2);
    rd(2'd2, v, t); chk("R8 count after wrap", v, (t - c - 1) % LAP);

    // R7: zero compare value, run through a full lap
    wr(2'd1, 8'd0, t);
    p0 = pulses;
    repeat (LAP + 20) @(negedge clk);
    chk("R7 no pulses with zero match", pulses - p0, 0);

    // R4: pause holds, resume continues
    wr(2'd0, 8'd0, t);
    rd(2'd2, f, t);
    repeat (20) @(negedge clk);
    rd(2'd2, v, t); chk("R4 frozen count", v, f);
    wr(2'd0, 8'd1, cR);
    repeat (7) @(negedge clk);
    rd(2'd2, v, t); chk("R4 resumed count", v, (f + t - cR - 1) % LAP);

    // R5: clear with run set holds zero
    wr(2'd0, 8'd3, t);
    repeat (5) @(negedge clk);
    rd(2'd2, v, t); chk("R5 count under clear", v, 0);
    repeat (5) @(negedge clk);
    rd(2'd2, v, t); chk("R5 count still zero", v, 0);
    wr(2'd1, 8'd3, t);
    wr(2'd0, 8'd1, c);
    expQ.push_back(c + 1 + 3);
    rd(2'd2, v, t); chk("R5 first count after clear", v, 1);
    wait (cyc > c + 1 + 3 + 2);
    rd(2'd2, v, t); chk("R5 count after clear", v, (t - c - 1) % LAP);

    // R9: freeze, then write compare equal to frozen count
    wr(2'd0, 8'd0, t);
    rd(2'd2, f, t);
    p0 = pulses;
    wr(2'd1, W'(f), t);
    repeat (20) @(negedge clk);
    chk("R9 no pulse when frozen at match", pulses - p0, 0);
    rd(2'd2, v, t); chk("R9 count unchanged", v, f);

    // R5: clear with run low also zeroes
    wr(2'd0, 8'd2, t);
    rd(2'd2, v, t); chk("R5 clear without run", v, 0);

    chk("R6 all expected pulses seen", expQ.size(), 0);
    finishRun();
  end
endmodule